// File: doc/BRIEF.md
# Square-Root Carry-Select Adder

This block adds two unsigned 15-bit operands and a carry-in, and returns a 15-bit sum and a carry-out. The operand is cut into three slices whose widths grow by one bit per slice toward the most significant end. The bottom slice is one ripple adder. Each upper slice runs two ripple adders side by side, one with a carry-in of 0 and one with a carry-in of 1. The real carry from the slice below then picks one of the two results with a multiplexer.

The slice widths grow upward because an upper slice has more time before its select carry arrives. Each slice's two candidate results are ready at about the moment its select settles. The worst path is the bottom ripple followed by one multiplexer per upper slice, so the delay grows with about the square root of the width. A parameter adds one output register, which gives one cycle of latency. When that register is left out, the block is purely combinational.

Top module: `sqrt_csel_adder`

## Requirements
- R1: `{cout_o, sum_o}` equals the 16-bit value `a_i + b_i + cin_i` for every combination of inputs.
- R2: Slice boundaries sit at bit 4 and bit 9 (slices 3..0, 8..4, 14..9; widths 4, 5, 6). A carry generated at the top of one slice must reach the slice above it. For example, 0x000F + 0x0001 = 0x0010 and 0x01F0 + 0x0010 = 0x0200.
- R3: The external carry-in enters the lowest slice. 0 + 0 with `cin_i`=1 gives a sum of 0x0001 and a carry-out of 0.
- R4: With both operands all-ones (0x7FFF), the result is sum 0x7FFE and carry-out 1 when `cin_i`=0, and sum 0x7FFF and carry-out 1 when `cin_i`=1.
- R5: A carry that propagates the full width through every slice reaches the carry-out. 0x7FFF + 0 with `cin_i`=1 gives sum 0x0000 and carry-out 1.
- R6: With the output register enabled (the default), the outputs show the result for inputs presented one clock edge earlier. While `rst_ni` is low, both outputs are 0.
- R7: In each upper slice, the result computed with carry-in 1 equals the result computed with carry-in 0, plus one, taken over the slice width plus its carry.
- R8: 0 + 0 with `cin_i`=0 gives sum 0 and carry-out 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | 15 | Operand A |
| b_i | input | 15 | Operand B |
| cin_i | input | 1 | Carry-in |
| sum_o | output | 15 | Sum |
| cout_o | output | 1 | Carry-out |

## Verification
Any fault inside a slice, such as a broken candidate adder or a select tied to the wrong carry, shows as a wrong sum in that slice's bit range. It also shows as a wrong carry in every slice above it whenever a carry has to cross the faulty boundary. With the default register, the fault appears on the ports one edge after the offending inputs. The directed vectors that cross the carry boundaries and propagate a carry through every slice target exactly those faults, because random operands seldom produce a long carry propagation.

// File: rtl/csel_pkg.sv
package csel_pkg;
  // lsb position of slice idx when slices grow by one bit from base width w0
  function automatic int grp_lsb(input int w0, input int idx);
    return idx * w0 + (idx * (idx - 1)) / 2;
  endfunction

  function automatic int grp_width(input int w0, input int idx);
    return w0 + idx;
  endfunction
endpackage

// File: rtl/csel_ripple.sv
module csel_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         ci_i,
  output logic [W-1:0] s_o,
  output logic         co_o
);
  logic [W:0] c;
  assign c[0] = ci_i;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign s_o[i]   = a_i[i] ^ b_i[i] ^ c[i];
    assign c[i+1]   = (a_i[i] & b_i[i]) | (c[i] & (a_i[i] ^ b_i[i]));
  end

  assign co_o = c[W];
endmodule

// File: rtl/csel_group.sv
module csel_group #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sel_i,
  output logic [W-1:0] s_o,
  output logic         co_o
);
  logic [W-1:0] s0, s1;
  logic         c0, c1;

  csel_ripple #(.W(W)) u_path0 (.a_i(a_i), .b_i(b_i), .ci_i(1'b0), .s_o(s0), .co_o(c0));
  csel_ripple #(.W(W)) u_path1 (.a_i(a_i), .b_i(b_i), .ci_i(1'b1), .s_o(s1), .co_o(c1));

  assign s_o  = sel_i ? s1 : s0;
  assign co_o = sel_i ? c1 : c0;

  // both candidates differ by exactly one
  p_dual_offset_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {c1, s1} == {c0, s0} + (W+1)'(1));

  // carry with cin=0 implies carry with cin=1
  p_carry_order_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c0 |-> c1);
endmodule

// File: rtl/sqrt_csel_adder.sv
module sqrt_csel_adder
  import csel_pkg::*;
#(
  parameter int BASE_W  = 4,
  parameter int NUM_GRP = 3,
  parameter bit REG_OUT = 1'b1,
  localparam int W      = grp_lsb(BASE_W, NUM_GRP)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [NUM_GRP:0] gc;
  logic [W-1:0]     sum_c;

  csel_ripple #(.W(BASE_W)) u_grp0 (
    .a_i (a_i[BASE_W-1:0]),
    .b_i (b_i[BASE_W-1:0]),
    .ci_i(cin_i),
    .s_o (sum_c[BASE_W-1:0]),
    .co_o(gc[1])
  );
  assign gc[0] = cin_i;

  for (genvar g = 1; g < NUM_GRP; g++) begin : g_sel
    localparam int LO = grp_lsb(BASE_W, g);
    localparam int GW = grp_width(BASE_W, g);
    csel_group #(.W(GW)) u_grp (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .a_i   (a_i[LO+GW-1:LO]),
      .b_i   (b_i[LO+GW-1:LO]),
      .sel_i (gc[g]),
      .s_o   (sum_c[LO+GW-1:LO]),
      .co_o  (gc[g+1])
    );
  end

  if (REG_OUT) begin : g_reg
    logic armed;
    logic [W:0] prev_res;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sum_o  <= '0;
        cout_o <= 1'b0;
        armed  <= 1'b0;
        prev_res <= '0;
      end else begin
        sum_o  <= sum_c;
        cout_o <= gc[NUM_GRP];
        armed  <= 1'b1;
        prev_res <= {1'b0, a_i} + {1'b0, b_i} + (W+1)'(cin_i);
      end
    end

    p_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed |-> ({cout_o, sum_o} == prev_res));
  end else begin : g_comb
    assign sum_o  = sum_c;
    assign cout_o = gc[NUM_GRP];
  end

  p_exact_sum_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {gc[NUM_GRP], sum_c} == {1'b0, a_i} + {1'b0, b_i} + (W+1)'(cin_i));

  p_full_prop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((a_i ^ b_i) == {W{1'b1}} && cin_i) |-> (gc[NUM_GRP] && sum_c == '0));
endmodule

// File: tb/sim_sqrt_csel_adder.sv
module sim_sqrt_csel_adder;
  localparam int W = 15;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum;
  logic         cout;
  int           n_chk = 0, n_fail = 0;
  bit           done = 1'b0;

  always #5 clk = ~clk;

  sqrt_csel_adder u0 (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .cin_i(cin),
    .sum_o(sum), .cout_o(cout)
  );

  task automatic check(input string req, input logic [W:0] got, input logic [W:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive at negedge, capture at posedge, compare at next negedge
  task automatic add_chk(input string req, input logic [W-1:0] x, input logic [W-1:0] y,
                         input logic c);
    logic [W:0] exp;
    @(negedge clk);
    a = x; b = y; cin = c;
    exp = {1'b0, x} + {1'b0, y} + (W+1)'(c);
    @(negedge clk);
    check(req, {cout, sum}, exp);
  endtask

  task automatic t_reset_r6;
    @(negedge clk);
    a = 15'h7FFF; b = 15'h7FFF; cin = 1'b1;
    @(negedge clk);
    check("R6 reset", {cout, sum}, 16'h0000);
    a = '0; b = '0; cin = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic t_zero_r8;
    add_chk("R8 zero", 15'h0000, 15'h0000, 1'b0);
  endtask

  task automatic t_cin_r3;
    add_chk("R3 cin only", 15'h0000, 15'h0000, 1'b1);
    add_chk("R3 cin into low slice", 15'h0007, 15'h0008, 1'b1);
  endtask

  task automatic t_bounds_r2;
    add_chk("R2 cross bit4", 15'h000F, 15'h0001, 1'b0);
    add_chk("R2 cross bit9", 15'h01F0, 15'h0010, 1'b0);
    add_chk("R2 cin across bit4", 15'h000F, 15'h0000, 1'b1);
    add_chk("R2 cross bit9 from low", 15'h01FF, 15'h0000, 1'b1);
    add_chk("R2 top slice carry", 15'h7E00, 15'h0200, 1'b0);
  endtask

  task automatic t_ones_r4;
    add_chk("R4 ones cin0", 15'h7FFF, 15'h7FFF, 1'b0);
    add_chk("R4 ones cin1", 15'h7FFF, 15'h7FFF, 1'b1);
  endtask

  task automatic t_prop_r5;
    add_chk("R5 full propagate", 15'h7FFF, 15'h0000, 1'b1);
    add_chk("R5 alternating propagate", 15'h5555, 15'h2AAA, 1'b1);
  endtask

  task automatic t_latency_r6;
    // new input must not appear before the capturing edge
    @(negedge clk);
    a = 15'h1234; b = 15'h0101; cin = 1'b0;
    @(negedge clk);
    a = 15'h0001; b = 15'h0001; cin = 1'b0;
    check("R6 one cycle latency", {cout, sum}, 16'h1335);
    @(negedge clk);
    check("R6 next result", {cout, sum}, 16'h0002);
  endtask

  task automatic t_random_r1;
    for (int i = 0; i < 300; i++) begin
      add_chk("R1 random", W'($urandom), W'($urandom), 1'($urandom));
    end
  endtask

  initial begin
    t_reset_r6();
    t_zero_r8();
    t_cin_r3();
    t_bounds_r2();
    t_ones_r4();
    t_prop_r5();
    t_latency_r6();
    t_random_r1();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule